// File: doc/BRIEF.md
# PCI configuration address generator

This block sits on the host side of a PCI bridge and holds the configuration address that software writes at I/O port 0CF8h. Writing that register only prepares a cycle. A later access to the data port at 0CFCh turns the stored fields into the address phase of a PCI configuration cycle. The block then raises a one-cycle request with the 32-bit AD value for that phase. It also flags whether the access belongs to the bridge's own registers and whether it will end in a master abort.

The CPU side is a plain I/O bus with a strobe, a write flag, a byte address, byte enables and write data. The bus returns read data and a claim flag in the same cycle. The stored word carries an enable bit, a bus number, a device number, a function number and a register number, at the same bit positions as the standard configuration mechanism. The bus number chooses the cycle type. When it is zero, the device number chooses one of three paths: a local cycle to the bridge, a one-hot IDSEL line, or an abort. A separate PCI bus reset input leaves the register alone and blocks new cycles while it is asserted.

Top module: `pci_cfg_addr_gen`

## Requirements
- R1: A write to 0CF8h updates the register only when all four byte enables are 1111. With any narrower enable pattern, the register keeps its value and io_hit_o stays low.
- R2: A write to the address register starts no cycle. A strobed access to 0CFCh with any nonzero byte enable, while the enable bit is set, raises cfg_req_o for exactly one cycle. That cycle is the one after the strobe. cfg_write_o copies the access direction.
- R3: When the bus number is 0 and the device number d is in 1..20, AD[11+d] is 1 and every other bit of AD[31:11] is 0. The function number appears on AD[10:8] and the register number on AD[7:2].
- R4: When the bus number is 0 and the device number is 0, cfg_local_o is 1 and cfg_abort_o is 0. AD equals the register number shifted left by 2, so the function number is ignored.
- R5: When the bus number is 0 and the device number is in 21..31, AD[31:11] is 0 and cfg_abort_o is 1. A read of the data port returns 32'hFFFF_FFFF on io_rdata_o in the strobe cycle.
- R6: When the bus number is nonzero, AD is {8'h00, bus[7:0], dev[4:0], fn[2:0], reg[5:0], 2'b01}.
- R7: AD[1:0] is 00 for every bus-0 cycle and 01 for every cycle with a nonzero bus number.
- R8: A full-width read of 0CF8h returns the register in the same cycle. The layout is bit 31 enable, bits 23:16 bus, 15:11 device, 10:8 function, 7:2 register. Bits 30:24 and 1:0 always read 0, whatever was written.
- R9: Bus 0, device 31, function 7, register 0 with a data-port write produces an ordinary configuration write with AD = 32'h0000_0700 and the abort flag set. No special encoding is used.
- R10: System reset clears the register to 0. pci_rst_i does not change the register, but while it is high a data-port access issues no cycle.
- R11: While the enable bit (bit 31) is 0, a data-port access is not claimed and issues no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| pci_rst_i | input | 1 | PCI bus reset in progress |
| io_strobe_i | input | 1 | I/O access valid this cycle |
| io_write_i | input | 1 | 1 = write, 0 = read |
| io_addr_i | input | 16 | I/O byte address (dword aligned) |
| io_be_i | input | 4 | Byte enables |
| io_wdata_i | input | 32 | Write data |
| io_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| io_hit_o | output | 1 | Access claimed by this block |
| cfg_req_o | output | 1 | One-cycle configuration cycle request |
| cfg_ad_o | output | 32 | AD value for the address phase |
| cfg_write_o | output | 1 | Configuration cycle is a write |
| cfg_local_o | output | 1 | Access goes to internal bridge registers |
| cfg_abort_o | output | 1 | Cycle will end in master abort |

## Verification
The device number is swept across its classes: 0, 1, a middle value, 20, 21 and 31. This separates the local path, the low and high ends of the IDSEL map, and the abort path. The same function and register values are reused each time, so a wrong shift or a dropped field shows up. A nonzero bus number checks the type one copy and its low code bits against the type zero cases. Narrow byte enables, a cleared enable bit and PCI bus reset are each applied against a known stored value, so an access that is wrongly taken shows as a changed read-back or a stray request.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

    localparam int IO_AW     = 16;
    localparam int BUS_W     = 8;
    localparam int DEV_W     = 5;
    localparam int FN_W      = 3;
    localparam int REG_W     = 6;
    localparam int AD_W      = 32;
    localparam int IDSEL_LSB = 11;
    localparam int IDSEL_W   = AD_W - IDSEL_LSB;

    localparam logic [IO_AW-1:0] CFG_ADDR_PORT = 16'h0CF8;
    localparam logic [IO_AW-1:0] CFG_DATA_PORT = 16'h0CFC;

    typedef struct packed {
        logic             en;
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] regn;
    } cfg_addr_t;

    typedef enum logic [1:0] {
        KIND_LOCAL = 2'd0,
        KIND_TYPE0 = 2'd1,
        KIND_ABORT = 2'd2,
        KIND_TYPE1 = 2'd3
    } cfg_kind_t;

    typedef struct packed {
        cfg_kind_t       kind;
        logic [AD_W-1:0] ad;
    } cfg_phase_t;

    function automatic logic [AD_W-1:0] pack_addr(cfg_addr_t a);
        return {a.en, 7'b0, a.bus, a.dev, a.fn, a.regn, 2'b00};
    endfunction

    function automatic cfg_addr_t unpack_addr(logic [AD_W-1:0] w);
        cfg_addr_t a;
        a.en   = w[31];
        a.bus  = w[23:16];
        a.dev  = w[15:11];
        a.fn   = w[10:8];
        a.regn = w[7:2];
        return a;
    endfunction

endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import pci_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AD_W-1:0] wdata,
    output cfg_addr_t       q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= unpack_addr(wdata);
    end

endmodule

// File: rtl/cfg_ad_encode.sv
module cfg_ad_encode
    import pci_cfg_pkg::*;
#(
    parameter int NUM_IDSEL = 20
) (
    input  cfg_addr_t  a,
    output cfg_phase_t ph
);

    logic [NUM_IDSEL-1:0] idsel;
    logic [IDSEL_W-1:0]   upper;

    for (genvar g = 0; g < NUM_IDSEL; g++) begin : g_idsel
        assign idsel[g] = (a.dev == DEV_W'(g + 1));
    end

    // bit 0 of upper is AD11, which no device drives
    assign upper = IDSEL_W'(idsel) << 1;

    always_comb begin
        if (a.bus != '0) begin
            ph.kind = KIND_TYPE1;
            ph.ad   = {8'h00, a.bus, a.dev, a.fn, a.regn, 2'b01};
        end else if (a.dev == '0) begin
            ph.kind = KIND_LOCAL;
            ph.ad   = {24'h0, a.regn, 2'b00};
        end else if (|idsel) begin
            ph.kind = KIND_TYPE0;
            ph.ad   = {upper, a.fn, a.regn, 2'b00};
        end else begin
            ph.kind = KIND_ABORT;
            ph.ad   = {{IDSEL_W{1'b0}}, a.fn, a.regn, 2'b00};
        end
    end

endmodule

// File: rtl/cfg_cycle_issue.sv
module cfg_cycle_issue
    import pci_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  logic            is_write,
    input  cfg_phase_t      ph,
    output logic            req,
    output logic [AD_W-1:0] ad,
    output logic            wr,
    output logic            local_acc,
    output logic            abort
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req       <= 1'b0;
            ad        <= '0;
            wr        <= 1'b0;
            local_acc <= 1'b0;
            abort     <= 1'b0;
        end else begin
            req <= fire;
            if (fire) begin
                ad        <= ph.ad;
                wr        <= is_write;
                local_acc <= (ph.kind == KIND_LOCAL);
                abort     <= (ph.kind == KIND_ABORT);
            end
        end
    end

endmodule

// File: rtl/pci_cfg_addr_gen.sv
module pci_cfg_addr_gen
    import pci_cfg_pkg::*;
#(
    parameter logic [IO_AW-1:0] ADDR_PORT = CFG_ADDR_PORT,
    parameter logic [IO_AW-1:0] DATA_PORT = CFG_DATA_PORT,
    parameter int               NUM_IDSEL = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pci_rst_i,
    input  logic             io_strobe_i,
    input  logic             io_write_i,
    input  logic [IO_AW-1:0] io_addr_i,
    input  logic [3:0]       io_be_i,
    input  logic [AD_W-1:0]  io_wdata_i,
    output logic [AD_W-1:0]  io_rdata_o,
    output logic             io_hit_o,
    output logic             cfg_req_o,
    output logic [AD_W-1:0]  cfg_ad_o,
    output logic             cfg_write_o,
    output logic             cfg_local_o,
    output logic             cfg_abort_o
);

    localparam int DW_AW = IO_AW - 2;

    cfg_addr_t  addr_q;
    cfg_phase_t phase;
    logic       at_addr, at_data;
    logic       hit_addr, hit_data;

    assign at_addr  = io_addr_i[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2];
    assign at_data  = io_addr_i[IO_AW-1:2] == DATA_PORT[IO_AW-1:2];
    assign hit_addr = io_strobe_i && at_addr && (io_be_i == 4'hF);
    assign hit_data = io_strobe_i && at_data && (io_be_i != 4'h0)
                      && addr_q.en && !pci_rst_i;

    cfg_addr_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (hit_addr && io_write_i),
        .wdata (io_wdata_i),
        .q     (addr_q)
    );

    cfg_ad_encode #(.NUM_IDSEL(NUM_IDSEL)) u_enc (
        .a  (addr_q),
        .ph (phase)
    );

    cfg_cycle_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .fire      (hit_data),
        .is_write  (io_write_i),
        .ph        (phase),
        .req       (cfg_req_o),
        .ad        (cfg_ad_o),
        .wr        (cfg_write_o),
        .local_acc (cfg_local_o),
        .abort     (cfg_abort_o)
    );

    assign io_hit_o = hit_addr || hit_data;

    always_comb begin
        io_rdata_o = '0;
        if (hit_addr && !io_write_i)
            io_rdata_o = pack_addr(addr_q);
        else if (hit_data && !io_write_i && phase.kind == KIND_ABORT)
            io_rdata_o = '1;
    end

    logic unused_ok;
    assign unused_ok = ^{DW_AW};

endmodule

// File: rtl/pci_cfg_addr_gen_chk.sv
module pci_cfg_addr_gen_chk
    import pci_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pci_rst_i,
    input logic             io_strobe_i,
    input logic             io_write_i,
    input logic [IO_AW-1:0] io_addr_i,
    input logic [3:0]       io_be_i,
    input logic [AD_W-1:0]  io_rdata_o,
    input logic             io_hit_o,
    input logic             cfg_req_o,
    input logic [AD_W-1:0]  cfg_ad_o,
    input logic             cfg_local_o,
    input logic             cfg_abort_o,
    input cfg_addr_t        addr_q
);

    logic to_addr, to_data, full_wr;
    assign to_addr = io_strobe_i && io_addr_i[IO_AW-1:2] == CFG_ADDR_PORT[IO_AW-1:2];
    assign to_data = io_strobe_i && io_addr_i[IO_AW-1:2] == CFG_DATA_PORT[IO_AW-1:2];
    assign full_wr = to_addr && io_write_i && io_be_i == 4'hF;

    p_narrow_kept_r1: assert property (@(posedge clk) disable iff (rst)
        (to_addr && io_be_i != 4'hF) |=> $stable(addr_q));

    p_narrow_unclaimed_r1: assert property (@(posedge clk) disable iff (rst)
        (to_addr && io_be_i != 4'hF) |-> !io_hit_o);

    p_req_after_data_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_req_o |-> $past(to_data && io_hit_o));

    p_type0_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_req_o && cfg_ad_o[1:0] == 2'b00 && !cfg_local_o && !cfg_abort_o)
        |-> $countones(cfg_ad_o[31:11]) == 1);

    p_local_not_abort_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_req_o |-> !(cfg_local_o && cfg_abort_o));

    p_abort_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_req_o && cfg_abort_o) |-> cfg_ad_o[31:11] == '0);

    p_type_code_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_req_o |-> cfg_ad_o[1] == 1'b0);

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (to_addr && io_hit_o && !io_write_i)
        |-> (io_rdata_o[1:0] == 2'b00 && io_rdata_o[30:24] == 7'h0));

    p_pcirst_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (pci_rst_i && !full_wr) |=> $stable(addr_q));

    p_pcirst_no_req_r10: assert property (@(posedge clk) disable iff (rst)
        pci_rst_i |=> !cfg_req_o);

    p_req_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_req_o |-> $past(addr_q.en));

endmodule

bind pci_cfg_addr_gen pci_cfg_addr_gen_chk u_chk (.*);

// File: tb/sim_pci_cfg_addr_gen.sv
module sim_pci_cfg_addr_gen;
    import pci_cfg_pkg::*;

    logic        clk = 0;
    logic        rst = 1;
    logic        pci_rst_i = 0;
    logic        io_strobe_i = 0;
    logic        io_write_i = 0;
    logic [15:0] io_addr_i = '0;
    logic [3:0]  io_be_i = '0;
    logic [31:0] io_wdata_i = '0;
    logic [31:0] io_rdata_o;
    logic        io_hit_o;
    logic        cfg_req_o;
    logic [31:0] cfg_ad_o;
    logic        cfg_write_o, cfg_local_o, cfg_abort_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] s_rdata;
    logic        s_hit;

    always #5 clk = ~clk;

    pci_cfg_addr_gen u0 (.*);

    function automatic logic [31:0] mk(bit en, logic [7:0] bus, logic [4:0] dev,
                                       logic [2:0] fn, logic [5:0] rg);
        return {en, 7'b0, bus, dev, fn, rg, 2'b00};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // drive one strobe cycle from a negedge; comb outputs sampled before the
    // posedge, registered outputs valid on return (next negedge)
    task automatic acc(logic [15:0] a, logic [3:0] be, bit wr, logic [31:0] d);
        io_strobe_i = 1; io_addr_i = a; io_be_i = be; io_write_i = wr; io_wdata_i = d;
        #1;
        s_rdata = io_rdata_o;
        s_hit   = io_hit_o;
        @(negedge clk);
        io_strobe_i = 0; io_write_i = 0; io_be_i = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        acc(16'h0CF8, 4'hF, 0, '0);
        chk("R10 reset value", s_rdata, 32'h0);
        chk("R10 no req after reset", {31'b0, cfg_req_o}, 32'h0);
    endtask

    task automatic t_narrow();
        acc(16'h0CF8, 4'hF, 1, mk(1, 8'h00, 5'd3, 3'd1, 6'h05));
        acc(16'h0CF8, 4'h3, 1, 32'hFFFF_FFFF);
        chk("R1 narrow write unclaimed", {31'b0, s_hit}, 32'h0);
        acc(16'h0CF8, 4'hF, 0, '0);
        chk("R1 narrow write ignored", s_rdata, mk(1, 8'h00, 5'd3, 3'd1, 6'h05));
    endtask

    task automatic t_start();
        acc(16'h0CF8, 4'hF, 1, mk(1, 8'h00, 5'd2, 3'd0, 6'h01));
        chk("R2 address write starts nothing", {31'b0, cfg_req_o}, 32'h0);
        acc(16'h0CFC, 4'h1, 0, '0);
        chk("R2 req after data read", {31'b0, cfg_req_o}, 32'h1);
        chk("R2 read direction", {31'b0, cfg_write_o}, 32'h0);
        idle();
        chk("R2 req lasts one cycle", {31'b0, cfg_req_o}, 32'h0);
    endtask

    task automatic t_type0(logic [4:0] d);
        acc(16'h0CF8, 4'hF, 1, mk(1, 8'h00, d, 3'd5, 6'h2A));
        acc(16'h0CFC, 4'hF, 1, 32'h1234_5678);
        chk("R3 idsel address", cfg_ad_o, (32'h1 << (11 + d)) | (32'd5 << 8) | (32'h2A << 2));
        chk("R3 write direction", {31'b0, cfg_write_o}, 32'h1);
        chk("R7 type zero code", {30'b0, cfg_ad_o[1:0]}, 32'h0);
    endtask

    task automatic t_local();
        acc(16'h0CF8, 4'hF, 1, mk(1, 8'h00, 5'd0, 3'd6, 6'h11));
        acc(16'h0CFC, 4'hF, 0, '0);
        chk("R4 local flag", {30'b0, cfg_local_o, cfg_abort_o}, 32'h2);
        chk("R4 local index, function ignored", cfg_ad_o, 32'h11 << 2);
    endtask

    task automatic t_abort(logic [4:0] d);
        acc(16'h0CF8, 4'hF, 1, mk(1, 8'h00, d, 3'd5, 6'h2A));
        acc(16'h0CFC, 4'hF, 0, '0);
        chk("R5 abort read all ones", s_rdata, 32'hFFFF_FFFF);
        chk("R5 abort flag", {30'b0, cfg_local_o, cfg_abort_o}, 32'h1);
        chk("R5 upper AD zero", cfg_ad_o, (32'd5 << 8) | (32'h2A << 2));
    endtask

    task automatic t_type1();
        acc(16'h0CF8, 4'hF, 1, mk(1, 8'h03, 5'd9, 3'd1, 6'h3F));
        acc(16'h0CFC, 4'hF, 0, '0);
        chk("R6 type one address", cfg_ad_o, {8'h00, 8'h03, 5'd9, 3'd1, 6'h3F, 2'b01});
        chk("R7 type one code", {30'b0, cfg_ad_o[1:0]}, 32'h1);
    endtask

    task automatic t_special();
        acc(16'h0CF8, 4'hF, 1, mk(1, 8'h00, 5'd31, 3'd7, 6'h00));
        acc(16'h0CFC, 4'hF, 1, 32'h0);
        chk("R9 ordinary write cycle", {29'b0, cfg_req_o, cfg_write_o, cfg_abort_o}, 32'h7);
        chk("R9 address value", cfg_ad_o, 32'h0000_0700);
    endtask

    task automatic t_reserved();
        acc(16'h0CF8, 4'hF, 1, 32'hFFFF_FFFF);
        acc(16'h0CF8, 4'hF, 0, '0);
        chk("R8 reserved bits read zero", s_rdata, 32'h80FF_FFFC);
    endtask

    task automatic t_pcirst();
        acc(16'h0CF8, 4'hF, 1, mk(1, 8'h00, 5'd4, 3'd2, 6'h08));
        pci_rst_i = 1;
        idle();
        acc(16'h0CFC, 4'hF, 0, '0);
        chk("R10 no cycle during PCI reset", {31'b0, cfg_req_o}, 32'h0);
        acc(16'h0CF8, 4'hF, 0, '0);
        chk("R10 kept through PCI reset", s_rdata, mk(1, 8'h00, 5'd4, 3'd2, 6'h08));
        pci_rst_i = 0;
        do_reset();
        acc(16'h0CF8, 4'hF, 0, '0);
        chk("R10 cleared by system reset", s_rdata, 32'h0);
    endtask

    task automatic t_enable();
        acc(16'h0CF8, 4'hF, 1, mk(0, 8'h00, 5'd4, 3'd0, 6'h00));
        acc(16'h0CFC, 4'hF, 0, '0);
        chk("R11 disabled access unclaimed", {31'b0, s_hit}, 32'h0);
        chk("R11 disabled access no req", {31'b0, cfg_req_o}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_narrow();
        t_start();
        t_type0(5'd1);
        t_type0(5'd7);
        t_type0(5'd20);
        t_local();
        t_abort(5'd21);
        t_abort(5'd31);
        t_type1();
        t_special();
        t_reserved();
        t_enable();
        t_pcirst();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule